// File: doc/BRIEF.md
# I2C Master Byte Transfer Engine

This block is a register-programmed I2C bus master for write and read transfers with 7-bit addressing. Software first loads the address byte into the data register. A single command write to the status register then produces a START condition and shifts that address byte out with no further action. After each byte, the engine holds SCL low, clears an active-low pending flag and pulses `irq`. Software answers by loading the next byte, which launches the next byte of clocking, or by writing a STOP command.

The clock control register sets the timing. It chooses standard or fast timing and the SCL period divider. It also decides whether a ninth acknowledge clock follows each byte, and which level the master returns on that clock when it is receiving. Both bus lines are open drain: the block only asserts pull-down enables and reads SDA back through `sdaIn`.

Top module: `i2c_master_engine`

## Requirements
- R1: After reset, `statusOut` reads 0x10 (only the pending-flag bit 4 set), `irq` is 0 and neither bus line is pulled low.
- R2: When the control register (select 2) has bit 3 set and the bus-busy flag (status bit 5) is clear, a status write (select 1) with bits 7 and 5 set pulls SDA low while SCL is high (a START). It also sets the busy flag and then clocks out the data register contents.
- R3: Bytes leave the data register (select 0) MSB first. The SDA level presented for each bit is the one sampled at the following rising SCL edge.
- R4: With clock-control (select 3) bit 7 set, each byte gets a ninth clock. In transmit mode the master releases SDA on it, and the SDA level seen on that clock is stored in status bit 0.
- R5: After the last clock of a byte, SCL is held low, status bit 4 reads 0 and `irq` pulses high for one cycle.
- R6: A data-register write while status bit 4 is 0 starts the next byte. A data-register write while a byte is being clocked has no effect on the bits sent.
- R7: A status write with bit 5 clear while a byte is pending produces a STOP: SDA rises while SCL is high, after which the busy flag reads 0 and both lines are released.
- R8: A START command is ignored while control bit 3 is clear or while the busy flag is set.
- R9: With clock-control bit 7 clear, each byte gets exactly 8 SCL clocks and status bit 0 keeps its previous value.
- R10: One quarter of an SCL period lasts (div+1) clocks when clock-control bit 5 is set and 4*(div+1) clocks otherwise, where div is clock-control bits 4:0. SCL stays high for two quarters.
- R11: With status bit 6 at 0 (receive), the master releases SDA for the 8 data bits and shifts the sampled levels into the data register, which is readable on `dataOut`. On the ninth clock it pulls SDA low if clock-control bit 6 is 0 and releases it if that bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 data, 1 status, 2 control, 3 clock control |
| regWdata | input | 8 | Register write data |
| sdaIn | input | 1 | Level of the SDA bus line |
| statusOut | output | 8 | {master, transmit, busy, pending_n, 000, last received bit} |
| dataOut | output | 8 | Data shift register contents |
| irq | output | 1 | One-cycle pulse at the end of each byte |
| sclDriveLow | output | 1 | Pull-down enable for SCL |
| sdaDriveLow | output | 1 | Pull-down enable for SDA |

## Verification
A load of the data register and a shift of that same register can fall on the same clock edge. This happens when software writes a byte while the engine is sampling a bit of the current one. The bench provokes it by issuing an extra write at a different cycle offset into each byte of a four-byte stimulus table, so that the offsets sweep across the sampling edge. It judges the outcome by rebuilding each byte from the SDA level seen at every rising SCL edge and comparing it with the byte that was intentionally loaded.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;
  localparam int DIV_W = 5;

  localparam logic [1:0] SEL_DATA   = 2'd0;
  localparam logic [1:0] SEL_STATUS = 2'd1;
  localparam logic [1:0] SEL_CTRL   = 2'd2;
  localparam logic [1:0] SEL_CLK    = 2'd3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_BIT, PH_HOLD, PH_STOP
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic lrbLoad;
    logic byteEnd;
    logic stopDone;
  } strobe_t;

  typedef struct packed {
    logic             ackClk;
    logic             ackBit;
    logic             fast;
    logic [DIV_W-1:0] div;
  } clkcfg_t;
endpackage

// File: rtl/i2cm_datapath.sv
`timescale 1ns/1ps
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic [7:0]        regWdata,
  input  logic              sdaIn,
  input  strobe_t           strobe,
  output clkcfg_t           cfg,
  output logic              txMode,
  output logic              dataMsb,
  output logic              startReq,
  output logic              stopReq,
  output logic              byteReq,
  output logic [7:0]        statusOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              irq
);
  logic master, busy, pendN, lrb, enable;
  logic [DATA_W-1:0] shiftReg;
  logic wrData, wrStat, wrCtrl, wrClk, dataLoad;

  assign wrData = regWr && (regSel == SEL_DATA);
  assign wrStat = regWr && (regSel == SEL_STATUS);
  assign wrCtrl = regWr && (regSel == SEL_CTRL);
  assign wrClk  = regWr && (regSel == SEL_CLK);

  assign startReq = wrStat && regWdata[7] && regWdata[5] && !busy && enable;
  assign stopReq  = wrStat && !regWdata[5] && busy && master && !pendN;
  assign byteReq  = wrData && busy && master && !pendN;
  // loads only when no byte, START or STOP is in flight
  assign dataLoad = wrData && (!busy || !pendN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      master   <= 1'b0;
      txMode   <= 1'b0;
      busy     <= 1'b0;
      pendN    <= 1'b1;
      lrb      <= 1'b0;
      enable   <= 1'b0;
      irq      <= 1'b0;
      shiftReg <= '0;
      cfg      <= '0;
    end else begin
      irq <= 1'b0;
      if (wrStat) begin
        master <= regWdata[7];
        txMode <= regWdata[6];
      end
      if (startReq) begin
        busy  <= 1'b1;
        pendN <= 1'b1;
      end
      if (stopReq || byteReq) pendN <= 1'b1;
      if (strobe.stopDone) busy <= 1'b0;
      if (strobe.byteEnd) begin
        pendN <= 1'b0;
        irq   <= 1'b1;
      end
      if (strobe.lrbLoad) lrb <= sdaIn;
      if (dataLoad) shiftReg <= DATA_W'(regWdata);
      else if (strobe.shiftEn) shiftReg <= {shiftReg[DATA_W-2:0], sdaIn};
      if (wrCtrl) enable <= regWdata[3];
      if (wrClk) cfg <= clkcfg_t'(regWdata);
    end
  end

  assign dataMsb   = shiftReg[DATA_W-1];
  assign dataOut   = shiftReg;
  assign statusOut = {master, txMode, busy, pendN, 3'b000, lrb};
endmodule

// File: rtl/i2cm_ctrl.sv
`timescale 1ns/1ps
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    stopReq,
  input  logic    byteReq,
  input  clkcfg_t cfg,
  input  logic    txMode,
  input  logic    dataMsb,
  output strobe_t strobe,
  output logic    sclLow,
  output logic    sdaLow
);
  localparam int CNT_W = DIV_W + 3;
  localparam int BIT_W = $clog2(BYTE_BITS + 1);
  localparam logic [BIT_W-1:0] ACK_IDX = BIT_W'(BYTE_BITS);

  phase_e           phase;
  logic [CNT_W-1:0] cnt, qLast, base;
  logic [1:0]       qIdx;
  logic [BIT_W-1:0] bitCnt, lastBit;
  logic             sdaLowR, tick, bitDrive;

  always_comb begin
    base  = CNT_W'(cfg.div) + CNT_W'(1);
    qLast = (cfg.fast ? base : (base << 2)) - CNT_W'(1);
  end

  assign tick    = (cnt == '0);
  assign lastBit = cfg.ackClk ? ACK_IDX : ACK_IDX - BIT_W'(1);

  always_comb begin
    if (bitCnt < ACK_IDX) bitDrive = txMode ? !dataMsb : 1'b0;
    else                  bitDrive = txMode ? 1'b0 : !cfg.ackBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      qIdx    <= '0;
      bitCnt  <= '0;
      sdaLowR <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (startReq) begin
          phase   <= PH_START;
          cnt     <= qLast;
          qIdx    <= '0;
          sdaLowR <= 1'b1;
        end
        PH_HOLD: if (byteReq) begin
          phase  <= PH_BIT;
          cnt    <= qLast;
          qIdx   <= '0;
          bitCnt <= '0;
        end else if (stopReq) begin
          phase <= PH_STOP;
          cnt   <= qLast;
          qIdx  <= '0;
        end
        default: if (!tick) begin
          cnt <= cnt - CNT_W'(1);
        end else begin
          cnt  <= qLast;
          qIdx <= qIdx + 2'd1;
          if (phase == PH_START && qIdx == 2'd1) begin
            phase  <= PH_BIT;
            qIdx   <= '0;
            bitCnt <= '0;
          end
          if (phase == PH_BIT) begin
            if (qIdx == 2'd0) sdaLowR <= bitDrive;
            if (qIdx == 2'd3) begin
              if (bitCnt == lastBit) phase <= PH_HOLD;
              else bitCnt <= bitCnt + BIT_W'(1);
            end
          end
          if (phase == PH_STOP) begin
            if (qIdx == 2'd0) sdaLowR <= 1'b1;
            if (qIdx == 2'd2) sdaLowR <= 1'b0;
            if (qIdx == 2'd3) phase <= PH_IDLE;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.shiftEn  = (phase == PH_BIT) && tick && (qIdx == 2'd2) && (bitCnt < ACK_IDX);
    strobe.lrbLoad  = (phase == PH_BIT) && tick && (qIdx == 2'd2) && (bitCnt == ACK_IDX);
    strobe.byteEnd  = (phase == PH_BIT) && tick && (qIdx == 2'd3) && (bitCnt == lastBit);
    strobe.stopDone = (phase == PH_STOP) && tick && (qIdx == 2'd3);
  end

  always_comb begin
    if (phase == PH_BIT || phase == PH_STOP) sclLow = !qIdx[1];
    else                                      sclLow = (phase == PH_HOLD);
  end
  assign sdaLow = sdaLowR;
endmodule

// File: rtl/i2c_master_engine.sv
`timescale 1ns/1ps
module i2c_master_engine
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [1:0] regSel,
  input  logic [7:0] regWdata,
  input  logic       sdaIn,
  output logic [7:0] statusOut,
  output logic [7:0] dataOut,
  output logic       irq,
  output logic       sclDriveLow,
  output logic       sdaDriveLow
);
  strobe_t strobe;
  clkcfg_t cfg;
  logic txMode, dataMsb, startReq, stopReq, byteReq;

  i2cm_datapath #(.DATA_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .sdaIn(sdaIn), .strobe(strobe), .cfg(cfg), .txMode(txMode), .dataMsb(dataMsb),
    .startReq(startReq), .stopReq(stopReq), .byteReq(byteReq),
    .statusOut(statusOut), .dataOut(dataOut), .irq(irq)
  );

  i2cm_ctrl #(.BYTE_BITS(8)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq), .byteReq(byteReq),
    .cfg(cfg), .txMode(txMode), .dataMsb(dataMsb), .strobe(strobe),
    .sclLow(sclDriveLow), .sdaLow(sdaDriveLow)
  );
endmodule

// File: rtl/i2cm_checker.sv
`timescale 1ns/1ps
module i2cm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sclLow,
  input logic       sdaLow,
  input logic [7:0] status,
  input logic       irq
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    !status[5] |-> (!sclLow && !sdaLow));

  assert_start_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaLow) && !sclLow) |-> (status[5] && !$past(status[5])));

  assert_irq_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !status[4]);

  assert_pending_holds_scl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !status[4] |-> sclLow);

  assert_stop_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sdaLow) && !sclLow) |-> ($past(!sclLow) && status[5]));
endmodule

bind i2c_master_engine i2cm_checker u_chk (
  .clk(clk), .rstN(rstN), .sclLow(sclDriveLow), .sdaLow(sdaDriveLow),
  .status(statusOut), .irq(irq)
);

// File: tb/i2c_master_engine_bench.sv
`timescale 1ns/1ps
module i2c_master_engine_bench;
  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0;
  logic [1:0] regSel = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] statusOut, dataOut;
  logic irq, sclDriveLow, sdaDriveLow, sclLine, sdaLine, slaveLow;

  int checks = 0, errors = 0;
  bit done = 0;

  // {slave acks, byte}
  localparam logic [8:0] VEC [4] = '{9'h13C, 9'h0FF, 9'h101, 9'h180};

  always #2.5 clk = ~clk;

  i2c_master_engine u_i2c_master_engine (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .sdaIn(sdaLine), .statusOut(statusOut), .dataOut(dataOut), .irq(irq),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

  // bus and slave model
  int fallCnt = 0, riseCnt = 0, startCnt = 0, stopCnt = 0, hc = 0, lastHigh = 0;
  logic [15:0] cap = '0;
  bit slaveAckEn = 0, slaveRx = 0;
  logic [7:0] rxPat = '0;
  logic prevScl = 1'b1, prevSda = 1'b1;

  function automatic logic slaveDrive(int fc, bit ackEn, bit rx, logic [7:0] pat);
    int idx;
    if (fc <= 0) return 1'b0;
    idx = (fc - 1) % 9;
    if (rx && idx < 8) return !pat[7-idx];
    if (ackEn && idx == 8) return 1'b1;
    return 1'b0;
  endfunction

  assign slaveLow = slaveDrive(fallCnt, slaveAckEn, slaveRx, rxPat);
  assign sclLine  = !sclDriveLow;
  assign sdaLine  = !(sdaDriveLow || slaveLow);

  always @(sclLine or sdaLine) begin
    if (prevScl && !sclLine) fallCnt++;
    if (!prevScl && sclLine) begin riseCnt++; cap = {cap[14:0], sdaLine}; end
    if (prevScl && sclLine && prevSda && !sdaLine) begin startCnt++; fallCnt = 0; end
    if (prevScl && sclLine && !prevSda && sdaLine) stopCnt++;
    prevScl = sclLine;
    prevSda = sdaLine;
  end

  always @(posedge clk) begin
    if (sclLine) hc++;
    else begin
      if (hc != 0) lastHigh = hc;
      hc = 0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic waitIrq(string req);
    bit seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (irq) seen = 1;
    end
    check(req, 32'(seen), 32'd1);
  endtask

  task automatic waitIdle(string req);
    for (int i = 0; i < 400 && statusOut[5]; i++) @(negedge clk);
    check(req, 32'(statusOut[5]), 32'd0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0, r0, p0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", 32'(statusOut), 32'h10);
    check("R1 lines", 32'({sclDriveLow, sdaDriveLow, irq}), 32'd0);

    // R8 START ignored while disabled
    wr(2'd3, 8'hA1);          // ack clock, fast, div 1
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hA6);
    s0 = startCnt;
    wr(2'd1, 8'hF0);
    repeat (20) @(negedge clk);
    check("R8 disabled busy", 32'(statusOut[5]), 32'd0);
    check("R8 disabled start", 32'(startCnt - s0), 32'd0);

    // R2/R3/R4/R5 address byte
    wr(2'd2, 8'h08);
    slaveAckEn = 1;
    s0 = startCnt; r0 = riseCnt;
    wr(2'd1, 8'hF0);
    check("R2 busy set", 32'(statusOut[5]), 32'd1);
    waitIrq("R5 irq after address");
    check("R2 start seen", 32'(startCnt - s0), 32'd1);
    check("R3 address msb first", 32'(cap[8:1]), 32'hA6);
    check("R4 nine clocks", 32'(riseCnt - r0), 32'd9);
    check("R4 ack captured", 32'(statusOut[0]), 32'd0);
    check("R5 pending low", 32'(statusOut[4]), 32'd0);
    @(negedge clk);
    check("R5 irq one cycle", 32'(irq), 32'd0);
    check("R5 scl held", 32'(sclDriveLow), 32'd1);
    check("R10 fast high time", 32'(lastHigh), 32'd4);

    // R6 table: bytes with a stray write at a varying offset
    for (int i = 0; i < 4; i++) begin
      slaveAckEn = VEC[i][8];
      r0 = riseCnt;
      wr(2'd0, VEC[i][7:0]);
      repeat (2 * i + 1) @(negedge clk);
      wr(2'd0, 8'h55);
      waitIrq("R6 irq");
      check("R6 byte sent unchanged", 32'(cap[8:1]), 32'(VEC[i][7:0]));
      check("R4 lrb level", 32'(statusOut[0]), 32'(!VEC[i][8]));
      check("R4 clocks", 32'(riseCnt - r0), 32'd9);
    end

    // R8 START ignored while busy
    s0 = startCnt;
    wr(2'd1, 8'hF0);
    repeat (20) @(negedge clk);
    check("R8 busy start", 32'(startCnt - s0), 32'd0);
    check("R8 still pending", 32'(statusOut[4]), 32'd0);

    // R7 STOP
    p0 = stopCnt;
    wr(2'd1, 8'hD0);
    waitIdle("R7 busy cleared");
    check("R7 stop seen", 32'(stopCnt - p0), 32'd1);
    check("R7 released", 32'({sclDriveLow, sdaDriveLow}), 32'd0);

    // R9 no ack clock; lrb stays 0 from the previous byte (0x80 acked)
    slaveAckEn = 0;
    wr(2'd3, 8'h21);
    wr(2'd0, 8'h42);
    r0 = riseCnt;
    wr(2'd1, 8'hF0);
    waitIrq("R9 irq");
    check("R9 eight clocks", 32'(riseCnt - r0), 32'd8);
    check("R9 byte", 32'(cap[7:0]), 32'h42);
    check("R9 lrb kept", 32'(statusOut[0]), 32'd0);
    wr(2'd1, 8'hD0);
    waitIdle("R9 stop");

    // R10 standard timing
    slaveAckEn = 1;
    wr(2'd3, 8'h81);
    wr(2'd0, 8'hA6);
    wr(2'd1, 8'hF0);
    waitIrq("R10 irq");
    check("R10 slow high time", 32'(lastHigh), 32'd16);
    wr(2'd1, 8'hD0);
    waitIdle("R10 stop");

    // R11 receive
    wr(2'd3, 8'hA1);
    wr(2'd0, 8'hA7);
    wr(2'd1, 8'hF0);
    waitIrq("R11 address irq");
    wr(2'd1, 8'hB0);          // receive, keep busy
    slaveAckEn = 0; slaveRx = 1; rxPat = 8'h5A;
    wr(2'd0, 8'hFF);
    waitIrq("R11 irq");
    check("R11 data in", 32'(dataOut), 32'h5A);
    check("R11 ack driven low", 32'(cap[0]), 32'd0);
    wr(2'd3, 8'hE1);
    rxPat = 8'hC3;
    wr(2'd0, 8'hFF);
    waitIrq("R11 irq2");
    check("R11 data in 2", 32'(dataOut), 32'hC3);
    check("R11 ack released", 32'(cap[0]), 32'd1);
    check("R11 lrb", 32'(statusOut[0]), 32'd1);
    slaveRx = 0;
    wr(2'd1, 8'hD0);
    waitIdle("R11 stop");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule